// File: doc/BRIEF.md
# Block-Transfer Request Framer and Responder

This block sits between a host-facing block-transfer register file and a command executor. The register file collects a request frame from the host into an inbound buffer and raises an attention pulse. The block then reads the frame header through a read port on that buffer and checks that the header's length byte agrees with the number of bytes received. A request for the interface-capabilities query is answered on the spot. Any other request is streamed to the executor, with its sequence byte held back and a rolling tag attached.

When the executor returns a response carrying the expected tag, the block writes the reply frame into the outbound buffer, puts the held sequence number back, and publishes the reply length. In the same cycle it tells the register file to drop the controller-busy flag, to raise controller-to-host attention and, if the interrupt conditions are met, to raise an interrupt. A response whose tag does not match is taken from the port and thrown away. A response too long for the outbound buffer is replaced with a short error reply.

Top module: `bt_req_responder`

## Requirements
- R1: When attention arrives and the inbound length is below 4, the block does nothing: it sends no stream beat, makes no outbound write and raises no clear, busy or attention pulse.
- R2: When the first inbound byte is not equal to the inbound length minus one, the block pulses `in_clr_o` once. It produces no reply, so busy stays set, and it sends no stream beat.
- R3: A frame whose byte 1 is 0x18 (application function code 0x06 shifted left by two) and whose byte 3 is 0x36 is answered locally with 10 outbound bytes: 9, byte1 OR 0x04, byte 2, byte 3, 0x00, 0x01, the inbound depth capped at 0xFF, the outbound depth capped at 0xFF, 10, 0x00. The reply length is 10 and no stream beat is sent.
- R4: Any other valid frame of length N is streamed as byte 1 followed by bytes 3 to N-1 (the sequence byte is skipped). `xq_last_o` is high only on the final beat, every beat carries the current tag, and data, last and tag stay stable while `xq_ready_i` is low.
- R5: A response whose tag differs from the expected tag is consumed in full and discarded. It writes no outbound byte, produces no reply pulse and leaves the expected tag unchanged.
- R6: A response of L bytes r0..rL-1 with the expected tag is written as L+1, r0, the saved sequence, r1..rL-1, with reply length L+2. The expected tag then advances by one, modulo 2^TAG_W, and the tag starts at 0 after reset.
- R7: A response with L greater than the outbound depth minus 2 is replaced by five bytes: 4, r0, the saved sequence, r1, 0xCA. The reply length is 5. A response with L equal to the depth minus 2 is framed normally.
- R8: With each reply the block pulses `busy_clr_o`, `atn_set_o` and `ob_len_we_o` together. `irq_req_o` pulses at the same time only when `irq_en_i` is 1, `irq_pend_i` is 0 and `irq_gate_i` is 1.
- R9: When attention and the first beat of a matching response are both present in the same idle cycle, the attention frame is handled to completion first and the response is framed afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| attn_i | input | 1 | Host-to-controller attention pulse |
| in_len_i | input | LEN_W | Number of bytes written into the inbound buffer |
| in_clr_o | output | 1 | Pulse: reset the inbound length (bad frame) |
| rq_addr_o | output | IA_W | Inbound buffer read address |
| rq_data_i | input | 8 | Inbound buffer read data (combinational) |
| ob_we_o | output | 1 | Outbound buffer write enable |
| ob_addr_o | output | OA_W | Outbound buffer write address |
| ob_data_o | output | 8 | Outbound buffer write data |
| ob_len_we_o | output | 1 | Pulse: load the outbound reply length |
| ob_len_o | output | LEN_W | Outbound reply length |
| busy_clr_o | output | 1 | Pulse: clear the controller-busy flag |
| atn_set_o | output | 1 | Pulse: set controller-to-host attention |
| irq_req_o | output | 1 | Pulse: raise the host interrupt |
| irq_en_i | input | 1 | Interrupt enable from the mask register |
| irq_pend_i | input | 1 | Interrupt already pending |
| irq_gate_i | input | 1 | Interface-level interrupt gate |
| xq_valid_o | output | 1 | Request stream valid |
| xq_ready_i | input | 1 | Request stream ready |
| xq_data_o | output | 8 | Request stream byte |
| xq_last_o | output | 1 | Final request byte |
| xq_tag_o | output | TAG_W | Tag attached to the request |
| xr_valid_i | input | 1 | Response stream valid |
| xr_ready_o | output | 1 | Response stream ready |
| xr_data_i | input | 8 | Response stream byte |
| xr_last_i | input | 1 | Final response byte |
| xr_tag_i | input | TAG_W | Tag of the response |

## Verification
The block can see a host attention pulse and the first beat of an executor response in the same idle cycle, because the two sources are independent. The bench sets up this collision on purpose. It first forwards a request so that a tag is outstanding, then loads a capability query, and drives the attention pulse and the first response beat on the same clock edge. It judges the outcome from the order of the reply-length loads: the capability reply length 10 must appear first and the response's length second. It also checks that the final outbound frame carries the response's sequence byte and that no beat of either source was lost.

// File: rtl/bt_rsp_pkg.sv
package bt_rsp_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_HDR, ST_EVAL, ST_LOCAL, ST_FWD,
    ST_RSEQ, ST_RSP, ST_FIN, ST_FERR, ST_DONE, ST_RDROP
  } bt_state_e;

  localparam logic [7:0] APP_FN       = 8'h06;
  localparam logic [7:0] CAP_QUERY    = 8'h36;
  localparam logic [7:0] CC_TOO_LONG  = 8'hCA;
  localparam int         CAP_BYTES    = 10;
  localparam int         ERR_BYTES    = 5;
  localparam int         MIN_FRAME    = 4;
endpackage

// File: rtl/bt_cap_reply.sv
module bt_cap_reply #(
  parameter int IBUF_DEPTH = 64,
  parameter int OBUF_DEPTH = 64
) (
  input  logic [3:0] idx_i,
  input  logic [7:0] fn_i,
  input  logic [7:0] seq_i,
  input  logic [7:0] cmd_i,
  output logic [7:0] byte_o
);
  localparam int IB_CAP = (IBUF_DEPTH > 255) ? 255 : IBUF_DEPTH;
  localparam int OB_CAP = (OBUF_DEPTH > 255) ? 255 : OBUF_DEPTH;
  localparam logic [7:0] IB_BYTE = 8'(IB_CAP);
  localparam logic [7:0] OB_BYTE = 8'(OB_CAP);

  always_comb begin
    case (idx_i)
      4'd0:    byte_o = 8'd9;
      4'd1:    byte_o = fn_i | 8'h04;
      4'd2:    byte_o = seq_i;
      4'd3:    byte_o = cmd_i;
      4'd4:    byte_o = 8'h00;
      4'd5:    byte_o = 8'h01;
      4'd6:    byte_o = IB_BYTE;
      4'd7:    byte_o = OB_BYTE;
      4'd8:    byte_o = 8'd10;
      default: byte_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/bt_tag_ctr.sv
module bt_tag_ctr #(
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_i,
  input  logic [TAG_W-1:0] cmp_i,
  output logic [TAG_W-1:0] tag_o,
  output logic             match_o
);
  logic [TAG_W-1:0] tag_q, tag_n;

  always_comb begin
    tag_n = tag_q;
    if (adv_i) tag_n = tag_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tag_q <= '0;
    else if (adv_i) tag_q <= tag_n;
  end

  assign tag_o   = tag_q;
  assign match_o = (cmp_i == tag_q);

  a_r6_tag_moves: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i |=> (tag_o != $past(tag_o)));
endmodule

// File: rtl/bt_reply_gate.sv
module bt_reply_gate (
  input  logic fire_i,
  input  logic irq_en_i,
  input  logic irq_pend_i,
  input  logic irq_gate_i,
  output logic busy_clr_o,
  output logic atn_set_o,
  output logic irq_req_o
);
  always_comb begin
    busy_clr_o = fire_i;
    atn_set_o  = fire_i;
    irq_req_o  = fire_i & irq_en_i & ~irq_pend_i & irq_gate_i;
  end
endmodule

// File: rtl/bt_req_responder.sv
module bt_req_responder
  import bt_rsp_pkg::*;
#(
  parameter int IBUF_DEPTH = 64,
  parameter int OBUF_DEPTH = 64,
  parameter int LEN_W      = 8,
  parameter int TAG_W      = 8,
  localparam int IA_W      = $clog2(IBUF_DEPTH),
  localparam int OA_W      = $clog2(OBUF_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             attn_i,
  input  logic [LEN_W-1:0] in_len_i,
  output logic             in_clr_o,
  output logic [IA_W-1:0]  rq_addr_o,
  input  logic [7:0]       rq_data_i,
  output logic             ob_we_o,
  output logic [OA_W-1:0]  ob_addr_o,
  output logic [7:0]       ob_data_o,
  output logic             ob_len_we_o,
  output logic [LEN_W-1:0] ob_len_o,
  output logic             busy_clr_o,
  output logic             atn_set_o,
  output logic             irq_req_o,
  input  logic             irq_en_i,
  input  logic             irq_pend_i,
  input  logic             irq_gate_i,
  output logic             xq_valid_o,
  input  logic             xq_ready_i,
  output logic [7:0]       xq_data_o,
  output logic             xq_last_o,
  output logic [TAG_W-1:0] xq_tag_o,
  input  logic             xr_valid_i,
  output logic             xr_ready_o,
  input  logic [7:0]       xr_data_i,
  input  logic             xr_last_i,
  input  logic [TAG_W-1:0] xr_tag_i
);
  localparam logic [LEN_W-1:0] L_MIN     = LEN_W'(MIN_FRAME);
  localparam logic [LEN_W-1:0] L_IBUF    = LEN_W'(IBUF_DEPTH);
  localparam logic [LEN_W-1:0] L_IBUF_M1 = LEN_W'(IBUF_DEPTH - 1);
  localparam logic [LEN_W-1:0] L_RSP_MAX = LEN_W'(OBUF_DEPTH - 2);
  localparam logic [LEN_W-1:0] L_CAP_END = LEN_W'(CAP_BYTES - 1);
  localparam logic [LEN_W-1:0] L_CAP     = LEN_W'(CAP_BYTES);
  localparam logic [LEN_W-1:0] L_ERR     = LEN_W'(ERR_BYTES);
  localparam logic [LEN_W-1:0] L_SAT     = '1;
  localparam logic [LEN_W:0]   W_OBUF    = (LEN_W+1)'(OBUF_DEPTH);
  localparam logic [7:0]       FN_MATCH  = APP_FN << 2;

  bt_state_e        st, st_n;
  logic [LEN_W-1:0] pos, pos_n;
  logic [LEN_W-1:0] rcnt, rcnt_n;
  logic [7:0]       hdr [4];
  logic [7:0]       hdr_n [4];
  logic [7:0]       seq_q, seq_n;
  logic [LEN_W-1:0] olen_q, olen_n;
  logic             attn_pend, attn_pend_n;
  logic             start, tag_adv, tag_match, fire;
  logic [7:0]       cap_byte;
  logic [LEN_W-1:0] f_end;
  logic [LEN_W:0]   widx;

  bt_cap_reply #(.IBUF_DEPTH(IBUF_DEPTH), .OBUF_DEPTH(OBUF_DEPTH)) u_cap (
    .idx_i (pos[3:0]),
    .fn_i  (hdr[1]),
    .seq_i (hdr[2]),
    .cmd_i (hdr[3]),
    .byte_o(cap_byte)
  );

  bt_tag_ctr #(.TAG_W(TAG_W)) u_tag (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv_i  (tag_adv),
    .cmp_i  (xr_tag_i),
    .tag_o  (xq_tag_o),
    .match_o(tag_match)
  );

  bt_reply_gate u_gate (
    .fire_i    (fire),
    .irq_en_i  (irq_en_i),
    .irq_pend_i(irq_pend_i),
    .irq_gate_i(irq_gate_i),
    .busy_clr_o(busy_clr_o),
    .atn_set_o (atn_set_o),
    .irq_req_o (irq_req_o)
  );

  assign f_end       = (in_len_i > L_IBUF) ? L_IBUF_M1 : (in_len_i - 1'b1);
  assign widx        = (rcnt == '0) ? (LEN_W+1)'(1) : ({1'b0, rcnt} + (LEN_W+1)'(2));
  assign start       = (st == ST_IDLE) && (attn_pend || attn_i);
  assign attn_pend_n = (attn_pend | attn_i) & ~start;
  assign rq_addr_o   = pos[IA_W-1:0];
  assign ob_len_o    = olen_q;

  always_comb begin
    st_n        = st;
    pos_n       = pos;
    rcnt_n      = rcnt;
    hdr_n       = hdr;
    seq_n       = seq_q;
    olen_n      = olen_q;
    ob_we_o     = 1'b0;
    ob_addr_o   = '0;
    ob_data_o   = '0;
    ob_len_we_o = 1'b0;
    in_clr_o    = 1'b0;
    xq_valid_o  = 1'b0;
    xq_data_o   = '0;
    xq_last_o   = 1'b0;
    xr_ready_o  = 1'b0;
    tag_adv     = 1'b0;
    fire        = 1'b0;
    case (st)
      ST_IDLE: begin
        if (start) begin
          if (in_len_i >= L_MIN) begin
            st_n  = ST_HDR;
            pos_n = '0;
          end
        end else if (xr_valid_i) begin
          if (tag_match) begin
            st_n    = ST_RSEQ;
            tag_adv = 1'b1;
          end else begin
            st_n = ST_RDROP;
          end
        end
      end
      ST_HDR: begin
        hdr_n[pos[1:0]] = rq_data_i;
        pos_n = pos + 1'b1;
        if (pos == LEN_W'(3)) st_n = ST_EVAL;
      end
      ST_EVAL: begin
        if (LEN_W'(hdr[0]) != (in_len_i - 1'b1)) begin
          in_clr_o = 1'b1;
          st_n     = ST_IDLE;
        end else if (hdr[1] == FN_MATCH && hdr[3] == CAP_QUERY) begin
          st_n  = ST_LOCAL;
          pos_n = '0;
        end else begin
          st_n  = ST_FWD;
          pos_n = LEN_W'(2);
          seq_n = hdr[2];
        end
      end
      ST_LOCAL: begin
        ob_we_o   = 1'b1;
        ob_addr_o = pos[OA_W-1:0];
        ob_data_o = cap_byte;
        pos_n     = pos + 1'b1;
        if (pos == L_CAP_END) begin
          olen_n = L_CAP;
          st_n   = ST_DONE;
        end
      end
      ST_FWD: begin
        xq_valid_o = 1'b1;
        xq_data_o  = (pos == LEN_W'(2)) ? hdr[1] : rq_data_i;
        xq_last_o  = (pos == f_end);
        if (xq_ready_i) begin
          pos_n = pos + 1'b1;
          if (pos == f_end) st_n = ST_IDLE;
        end
      end
      ST_RSEQ: begin
        ob_we_o   = 1'b1;
        ob_addr_o = OA_W'(2);
        ob_data_o = seq_q;
        rcnt_n    = '0;
        st_n      = ST_RSP;
      end
      ST_RSP: begin
        xr_ready_o = 1'b1;
        if (xr_valid_i) begin
          ob_we_o   = (widx < W_OBUF);
          ob_addr_o = widx[OA_W-1:0];
          ob_data_o = xr_data_i;
          if (rcnt != L_SAT) rcnt_n = rcnt + 1'b1;
          if (xr_last_i) st_n = ST_FIN;
        end
      end
      ST_FIN: begin
        ob_we_o   = 1'b1;
        ob_addr_o = '0;
        if (rcnt > L_RSP_MAX) begin
          ob_data_o = 8'd4;
          st_n      = ST_FERR;
        end else begin
          ob_data_o = 8'(rcnt + 1'b1);
          olen_n    = rcnt + LEN_W'(2);
          st_n      = ST_DONE;
        end
      end
      ST_FERR: begin
        ob_we_o   = 1'b1;
        ob_addr_o = OA_W'(4);
        ob_data_o = CC_TOO_LONG;
        olen_n    = L_ERR;
        st_n      = ST_DONE;
      end
      ST_DONE: begin
        ob_len_we_o = 1'b1;
        fire        = 1'b1;
        st_n        = ST_IDLE;
      end
      ST_RDROP: begin
        xr_ready_o = 1'b1;
        if (xr_valid_i && xr_last_i) st_n = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      pos       <= '0;
      rcnt      <= '0;
      seq_q     <= '0;
      olen_q    <= '0;
      attn_pend <= 1'b0;
      for (int i = 0; i < 4; i++) hdr[i] <= '0;
    end else begin
      st        <= st_n;
      pos       <= pos_n;
      rcnt      <= rcnt_n;
      seq_q     <= seq_n;
      olen_q    <= olen_n;
      attn_pend <= attn_pend_n;
      hdr       <= hdr_n;
    end
  end

  a_r2_clr_without_reply: assert property (@(posedge clk) disable iff (!rst_n)
    in_clr_o |-> (!busy_clr_o && !xq_valid_o && !ob_we_o));

  a_r3_local_no_stream: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LOCAL) |-> !xq_valid_o);

  a_r4_stream_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (xq_valid_o && !xq_ready_i) |=> (xq_valid_o && $stable(xq_data_o)
                                     && $stable(xq_last_o) && $stable(xq_tag_o)));

  a_r5_drop_keeps_tag: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RDROP) |=> $stable(xq_tag_o));

  a_r5_drop_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RDROP) |-> (!ob_we_o && !ob_len_we_o));

  a_r8_irq_terms: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_o |-> (ob_len_we_o && irq_en_i && irq_gate_i && !irq_pend_i));

  a_r8_reply_pulses: assert property (@(posedge clk) disable iff (!rst_n)
    ob_len_we_o |-> (busy_clr_o && atn_set_o));
endmodule

// File: tb/bt_req_responder_test.sv
`timescale 1ns/1ps
module bt_req_responder_test;
  localparam int IA_W = 6;
  localparam int OA_W = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic attn_i;
  logic [7:0] in_len_i;
  logic in_clr_o;
  logic [IA_W-1:0] rq_addr_o;
  logic [7:0] rq_data_i;
  logic ob_we_o;
  logic [OA_W-1:0] ob_addr_o;
  logic [7:0] ob_data_o;
  logic ob_len_we_o;
  logic [7:0] ob_len_o;
  logic busy_clr_o, atn_set_o, irq_req_o;
  logic irq_en_i, irq_pend_i, irq_gate_i;
  logic xq_valid_o, xq_ready_i, xq_last_o;
  logic [7:0] xq_data_o, xq_tag_o;
  logic xr_valid_i, xr_ready_o, xr_last_i;
  logic [7:0] xr_data_i, xr_tag_i;

  logic [7:0] ibuf [64];
  logic [7:0] obuf [64];
  logic [7:0] rdat [80];
  logic [7:0] qdat [32];
  logic       qlst [32];
  logic [7:0] qtag [32];
  logic [7:0] olog [8];
  int qn, done_n, clr_n, busy_n, atn_n, irq_n, wr_n;
  int vectors = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  assign rq_data_i = ibuf[rq_addr_o];

  bt_req_responder uut (
    .clk(clk), .rst_n(rst_n), .attn_i(attn_i), .in_len_i(in_len_i),
    .in_clr_o(in_clr_o), .rq_addr_o(rq_addr_o), .rq_data_i(rq_data_i),
    .ob_we_o(ob_we_o), .ob_addr_o(ob_addr_o), .ob_data_o(ob_data_o),
    .ob_len_we_o(ob_len_we_o), .ob_len_o(ob_len_o),
    .busy_clr_o(busy_clr_o), .atn_set_o(atn_set_o), .irq_req_o(irq_req_o),
    .irq_en_i(irq_en_i), .irq_pend_i(irq_pend_i), .irq_gate_i(irq_gate_i),
    .xq_valid_o(xq_valid_o), .xq_ready_i(xq_ready_i), .xq_data_o(xq_data_o),
    .xq_last_o(xq_last_o), .xq_tag_o(xq_tag_o),
    .xr_valid_i(xr_valid_i), .xr_ready_o(xr_ready_o), .xr_data_i(xr_data_i),
    .xr_last_i(xr_last_i), .xr_tag_i(xr_tag_i)
  );

  // executor back-pressure: ready low one cycle in three
  always @(negedge clk) begin
    cyc <= cyc + 1;
    xq_ready_i <= ((cyc % 3) != 0);
  end

  // port monitor
  always @(posedge clk) begin
    if (rst_n) begin
      if (ob_we_o) begin obuf[ob_addr_o] <= ob_data_o; wr_n <= wr_n + 1; end
      if (ob_len_we_o) begin
        if (done_n < 8) olog[done_n] <= ob_len_o;
        done_n <= done_n + 1;
      end
      if (in_clr_o)   clr_n  <= clr_n + 1;
      if (busy_clr_o) busy_n <= busy_n + 1;
      if (atn_set_o)  atn_n  <= atn_n + 1;
      if (irq_req_o)  irq_n  <= irq_n + 1;
      if (xq_valid_o && xq_ready_i && qn < 32) begin
        qdat[qn] <= xq_data_o; qlst[qn] <= xq_last_o; qtag[qn] <= xq_tag_o;
        qn <= qn + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_counts();
    @(negedge clk);
    qn = 0; done_n = 0; clr_n = 0; busy_n = 0; atn_n = 0; irq_n = 0; wr_n = 0;
  endtask

  task automatic pulse_attn();
    @(negedge clk);
    attn_i = 1'b1;
    @(negedge clk);
    attn_i = 1'b0;
  endtask

  task automatic send_rsp(input logic [7:0] tag, input int n);
    for (int i = 0; i < n; i++) begin
      xr_valid_i = 1'b1; xr_data_i = rdat[i]; xr_last_i = (i == n - 1); xr_tag_i = tag;
      while (!xr_ready_o) @(negedge clk);
      @(negedge clk);
    end
    xr_valid_i = 1'b0; xr_last_i = 1'b0;
  endtask

  task automatic forward(input logic [7:0] fn, input logic [7:0] seq, input logic [7:0] cmd);
    ibuf[0] = 8'd3; ibuf[1] = fn; ibuf[2] = seq; ibuf[3] = cmd; in_len_i = 8'd4;
    pulse_attn();
    repeat (30) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!xq_valid_o && !xr_ready_o, "R4 reset idle stream", {xq_valid_o, xr_ready_o}, 0);
    chk(!ob_we_o && !busy_clr_o && !in_clr_o, "R8 reset no pulses", {ob_we_o, busy_clr_o, in_clr_o}, 0);
  endtask

  task automatic t_short();
    clear_counts();
    ibuf[0] = 8'd2; ibuf[1] = 8'h18; ibuf[2] = 8'h01; in_len_i = 8'd3;
    pulse_attn();
    repeat (30) @(negedge clk);
    chk(qn == 0 && wr_n == 0, "R1 short frame no activity", qn + wr_n, 0);
    chk(clr_n == 0 && busy_n == 0 && atn_n == 0, "R1 short frame no pulses", clr_n + busy_n + atn_n, 0);
  endtask

  task automatic t_mismatch();
    clear_counts();
    ibuf[0] = 8'd7; ibuf[1] = 8'h18; ibuf[2] = 8'h02; ibuf[3] = 8'h36; ibuf[4] = 8'h00;
    in_len_i = 8'd5;
    pulse_attn();
    repeat (30) @(negedge clk);
    chk(clr_n == 1, "R2 length clear pulse", clr_n, 1);
    chk(busy_n == 0 && done_n == 0 && qn == 0, "R2 no reply", busy_n + done_n + qn, 0);
  endtask

  task automatic t_capability();
    logic [7:0] exp [10];
    exp = '{8'd9, 8'h1C, 8'h55, 8'h36, 8'h00, 8'h01, 8'h40, 8'h40, 8'd10, 8'h00};
    clear_counts();
    irq_en_i = 1; irq_pend_i = 0; irq_gate_i = 1;
    ibuf[0] = 8'd3; ibuf[1] = 8'h18; ibuf[2] = 8'h55; ibuf[3] = 8'h36; in_len_i = 8'd4;
    pulse_attn();
    repeat (30) @(negedge clk);
    for (int i = 0; i < 10; i++)
      chk(obuf[i] == exp[i], $sformatf("R3 capability byte %0d", i), obuf[i], exp[i]);
    chk(done_n == 1 && olog[0] == 8'd10, "R3 capability length", olog[0], 10);
    chk(qn == 0, "R3 no stream beat", qn, 0);
    chk(busy_n == 1 && atn_n == 1, "R8 busy and attention pulses", busy_n * 16 + atn_n, 8'h11);
    chk(irq_n == 1, "R8 irq when allowed", irq_n, 1);
  endtask

  task automatic t_forward();
    logic [7:0] exp [5];
    exp = '{8'h1C, 8'h01, 8'hA0, 8'hA1, 8'hA2};
    clear_counts();
    ibuf[0] = 8'd6; ibuf[1] = 8'h1C; ibuf[2] = 8'h21; ibuf[3] = 8'h01;
    ibuf[4] = 8'hA0; ibuf[5] = 8'hA1; ibuf[6] = 8'hA2; in_len_i = 8'd7;
    pulse_attn();
    repeat (40) @(negedge clk);
    chk(qn == 5, "R4 beat count", qn, 5);
    for (int i = 0; i < 5; i++) begin
      chk(qdat[i] == exp[i], $sformatf("R4 beat %0d data", i), qdat[i], exp[i]);
      chk(qlst[i] == (i == 4), $sformatf("R4 beat %0d last", i), qlst[i], (i == 4));
    end
    chk(qtag[0] == 8'd0, "R6 first tag is zero", qtag[0], 0);
  endtask

  task automatic t_stale();
    clear_counts();
    rdat[0] = 8'h1C; rdat[1] = 8'h01; rdat[2] = 8'hEE;
    send_rsp(8'd5, 3);
    repeat (10) @(negedge clk);
    chk(wr_n == 0 && done_n == 0, "R5 stale response discarded", wr_n + done_n, 0);
    chk(busy_n == 0, "R5 stale response no pulse", busy_n, 0);
  endtask

  task automatic t_response();
    logic [7:0] exp [6];
    exp = '{8'd5, 8'h1C, 8'h21, 8'h01, 8'h00, 8'h77};
    clear_counts();
    irq_en_i = 1; irq_pend_i = 0; irq_gate_i = 0;
    rdat[0] = 8'h1C; rdat[1] = 8'h01; rdat[2] = 8'h00; rdat[3] = 8'h77;
    send_rsp(8'd0, 4);
    repeat (10) @(negedge clk);
    for (int i = 0; i < 6; i++)
      chk(obuf[i] == exp[i], $sformatf("R6 response byte %0d", i), obuf[i], exp[i]);
    chk(done_n == 1 && olog[0] == 8'd6, "R6 response length", olog[0], 6);
    chk(busy_n == 1 && irq_n == 0, "R8 gate off suppresses irq", irq_n, 0);
  endtask

  task automatic t_overflow();
    clear_counts();
    forward(8'h20, 8'h33, 8'h05);
    chk(qn == 2 && qdat[0] == 8'h20 && qdat[1] == 8'h05, "R4 short forward", qdat[1], 8'h05);
    chk(qtag[0] == 8'd1, "R5 tag kept by drop and R6 advanced", qtag[0], 1);
    for (int i = 0; i < 80; i++) rdat[i] = 8'(8'h40 + i);
    clear_counts();
    send_rsp(8'd1, 62);
    repeat (10) @(negedge clk);
    chk(olog[0] == 8'd64, "R7 boundary length", olog[0], 64);
    chk(obuf[0] == 8'd63 && obuf[2] == 8'h33, "R7 boundary header", obuf[0], 63);
    chk(obuf[63] == rdat[61], "R7 boundary last byte", obuf[63], rdat[61]);
    forward(8'h20, 8'h44, 8'h05);
    clear_counts();
    irq_en_i = 1; irq_pend_i = 1; irq_gate_i = 1;
    send_rsp(8'd2, 70);
    repeat (10) @(negedge clk);
    chk(olog[0] == 8'd5 && done_n == 1, "R7 error reply length", olog[0], 5);
    chk(obuf[0] == 8'd4 && obuf[1] == 8'h40, "R7 error len and first", obuf[0], 4);
    chk(obuf[2] == 8'h44 && obuf[3] == 8'h41, "R7 error seq and command", obuf[3], 8'h41);
    chk(obuf[4] == 8'hCA, "R7 error code", obuf[4], 8'hCA);
    chk(irq_n == 0 && busy_n == 1, "R8 pending irq suppresses", irq_n, 0);
  endtask

  task automatic t_collision();
    forward(8'h20, 8'h55, 8'h07);
    ibuf[0] = 8'd3; ibuf[1] = 8'h18; ibuf[2] = 8'h66; ibuf[3] = 8'h36; in_len_i = 8'd4;
    rdat[0] = 8'h1C; rdat[1] = 8'h10; rdat[2] = 8'h00;
    clear_counts();
    fork
      begin attn_i = 1'b1; @(negedge clk); attn_i = 1'b0; end
      send_rsp(8'd3, 3);
    join
    repeat (30) @(negedge clk);
    chk(done_n == 2, "R9 both replies", done_n, 2);
    chk(olog[0] == 8'd10, "R9 attention first", olog[0], 10);
    chk(olog[1] == 8'd5, "R9 response second", olog[1], 5);
    chk(obuf[0] == 8'd4 && obuf[2] == 8'h55 && obuf[3] == 8'h10, "R9 final frame", obuf[2], 8'h55);
  endtask

  initial begin
    rst_n = 0; attn_i = 0; in_len_i = 0; irq_en_i = 0; irq_pend_i = 0; irq_gate_i = 0;
    xr_valid_i = 0; xr_data_i = 0; xr_last_i = 0; xr_tag_i = 0; xq_ready_i = 1;
    qn = 0; done_n = 0; clr_n = 0; busy_n = 0; atn_n = 0; irq_n = 0; wr_n = 0;
    for (int i = 0; i < 64; i++) begin ibuf[i] = 8'h00; obuf[i] = 8'h00; end
    for (int i = 0; i < 8; i++) olog[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_short();
    t_mismatch();
    t_capability();
    t_forward();
    t_stale();
    t_response();
    t_overflow();
    t_collision();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      vectors++;
      fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule